// File: doc/BRIEF.md
# Display Controller Register Bank

This block holds the software-visible configuration and status of a display controller. A simple synchronous bus reaches six 32-bit registers: control, three timing words, status and sub-panel. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The block decodes the stored words into configuration fields for the rest of the controller. It does not fetch pixels and does not generate display timing.

The frame engine sends one-cycle event strobes: frame finished, palette loaded and sync error. The bank holds each strobe as a sticky status flag and drives one level-sensitive interrupt from these flags. The interrupt mask in the control register gates frame-done and palette-loaded; sync-error always raises the interrupt. When a control write changes the enable bit, the bank emits a one-cycle pulse so the frame engine can start or stop. Turning enable on or off also updates the status flags as described in R9 and R10.

Top module: `disp_ctrl_regs`

## Requirements
- R1: After reset every stored register and flag is zero. Reads then return these values: control `0xFE000C34`, timing0 `0x0000000F`, timing1 `0x0`, timing2 `0xFC000000`, status `0x0`, sub-panel `0x0`. After reset `irq` and `en_change` are low.
- R2: Control (offset 0x00) fields are:
  - enable in bit 0
  - mono in bit 1
  - interrupt mask in bits 4:3 (bit 3 gates frame-done, bit 4 gates palette-loaded)
  - TFT in bit 7
  - load mode in bits 21:20
  
  Written bits under mask `0x01CFF300` are kept as they are. A control read returns the fields in place, the TFT flag also copied into bit 23, the kept bits, all ORed with `0xFE000C34`.
- R3: Timing0 (0x04) and timing1 (0x08) store the whole written word. Bits 9:0 are width-1 and height-1, and bits 31:10 are the extra timing fields. Timing2 (0x0C) stores the whole word. A timing0 read ORs in `0x0000000F`, and a timing2 read ORs in `0xFC000000`.
- R4: A sub-panel (0x14) write stores only the bits under `0xA1FFFFFF`, and reads return the stored value.
- R5: Status (0x10) reads show palette-loaded in bit 6, sync-error in bit 2 and frame-done in bit 0, with other bits zero. Writes to status change nothing.
- R6: Each event strobe sets its status flag, and the flag stays set until an enable transition clears it.
- R7: `irq` = (frame-done AND mask bit 3) OR (palette-loaded AND mask bit 4) OR sync-error. Sync-error is not masked.
- R8: `en_change` is high for exactly the one cycle after a control write whose enable bit differs from the stored enable. A control write that keeps enable unchanged gives no pulse.
- R9: A control write that clears enable also clears sync-error. It sets frame-done unless the written load mode equals 1.
- R10: A control write that sets enable clears frame-done and palette-loaded.
- R11: An access to any other offset (including a misaligned one) reads zero and changes no register.
- R12: An event strobe in the same cycle as a control write that would clear its flag wins, so the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_frame_done | input | 1 | Frame finished strobe |
| ev_palette_done | input | 1 | Palette loaded strobe |
| ev_sync_err | input | 1 | Sync error strobe |
| irq | output | 1 | Level interrupt |
| en_change | output | 1 | One-cycle pulse on enable change |
| cfg_enable | output | 1 | Stored enable |
| cfg_load_mode | output | 2 | Stored load mode |
| cfg_tft | output | 1 | Stored TFT flag |
| cfg_mono | output | 1 | Stored mono flag |
| cfg_width_m1 | output | SIZE_W | Width minus one |
| cfg_height_m1 | output | SIZE_W | Height minus one |
| cfg_htiming | output | 32-SIZE_W | Upper timing0 field |
| cfg_vtiming | output | 32-SIZE_W | Upper timing1 field |
| cfg_timing2 | output | 32 | Timing2 word |
| cfg_subpanel | output | 32 | Sub-panel word |

## Verification
The control write path is tried with three patterns: a sparse word, an all-ones word and an all-zeros word. Together they show whether each field lands in its own bit, whether TFT is copied into bit 23, and whether the fixed-ones mask is applied. Events are given one at a time under different mask settings, which separates masked sources from the unmasked sync-error. Disables with load mode 0 and load mode 1, an enable that changes nothing, and an event that collides with a disable each test one branch of the enable-transition logic. Writes to the status offset and to unmapped or misaligned offsets are followed by read-back, which shows that they changed no state.

// File: rtl/disp_regs_pkg.sv
// Shared constants and types of the display register bank.
// Assumes a 32-bit register word and byte offsets.
package disp_regs_pkg;
    localparam int REG_W = 32;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_TIM0 = 'h04;
    localparam int OFF_TIM1 = 'h08;
    localparam int OFF_TIM2 = 'h0c;
    localparam int OFF_STAT = 'h10;
    localparam int OFF_SUBP = 'h14;

    localparam logic [REG_W-1:0] CTRL_KEEP_MASK = 32'h01cff300;
    localparam logic [REG_W-1:0] CTRL_RD_ONES   = 32'hfe000c34;
    localparam logic [REG_W-1:0] TIM0_RD_ONES   = 32'h0000000f;
    localparam logic [REG_W-1:0] TIM2_RD_ONES   = 32'hfc000000;
    localparam logic [REG_W-1:0] SUBP_WR_MASK   = 32'ha1ffffff;

    localparam int CB_EN      = 0;
    localparam int CB_MONO    = 1;
    localparam int CB_IMASK   = 3;
    localparam int CB_TFT     = 7;
    localparam int CB_TFT_DUP = 23;
    localparam int CB_MODE    = 20;

    localparam int SB_FD = 0;
    localparam int SB_SE = 2;
    localparam int SB_PD = 6;

    localparam logic [1:0] MODE_NO_AUTO_FD = 2'd1;

    typedef struct packed {
        logic ctrl;
        logic tim0;
        logic tim1;
        logic tim2;
        logic stat;
        logic subp;
    } reg_sel_t;
endpackage

// File: rtl/disp_addr_decode.sv
// Decodes a byte offset into a one-hot register select.
// Assumes a full-width compare, so a misaligned offset selects nothing.
module disp_addr_decode
    import disp_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    // Compare the offset against each mapped register.
    always_comb begin
        sel.ctrl = (addr == ADDR_W'(OFF_CTRL));
        sel.tim0 = (addr == ADDR_W'(OFF_TIM0));
        sel.tim1 = (addr == ADDR_W'(OFF_TIM1));
        sel.tim2 = (addr == ADDR_W'(OFF_TIM2));
        sel.stat = (addr == ADDR_W'(OFF_STAT));
        sel.subp = (addr == ADDR_W'(OFF_SUBP));
    end
endmodule

// File: rtl/disp_cfg_store.sv
// Holds the writable configuration registers and detects enable transitions.
// Assumes one write per cycle. The transition strobes are valid in the write cycle.
module disp_cfg_store
    import disp_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  reg_sel_t         sel,
    input  logic [REG_W-1:0] wdata,
    output logic             en_q,
    output logic             mono_q,
    output logic             tft_q,
    output logic [1:0]       imask_q,
    output logic [1:0]       mode_q,
    output logic [REG_W-1:0] keep_q,
    output logic [REG_W-1:0] tim0_q,
    output logic [REG_W-1:0] tim1_q,
    output logic [REG_W-1:0] tim2_q,
    output logic [REG_W-1:0] subp_q,
    output logic             en_rise,
    output logic             en_fall,
    output logic [1:0]       new_mode,
    output logic             chg_pulse
);
    logic ctrl_wr;

    // Derive the enable transition strobes from the current control write.
    always_comb begin
        ctrl_wr  = wr & sel.ctrl;
        new_mode = wdata[CB_MODE +: 2];
        en_rise  = ctrl_wr &  wdata[CB_EN] & ~en_q;
        en_fall  = ctrl_wr & ~wdata[CB_EN] &  en_q;
    end

    // Register storage, with the write mask applied per register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            mono_q    <= 1'b0;
            tft_q     <= 1'b0;
            imask_q   <= '0;
            mode_q    <= '0;
            keep_q    <= '0;
            tim0_q    <= '0;
            tim1_q    <= '0;
            tim2_q    <= '0;
            subp_q    <= '0;
            chg_pulse <= 1'b0;
        end else begin
            chg_pulse <= en_rise | en_fall;
            if (ctrl_wr) begin
                en_q    <= wdata[CB_EN];
                mono_q  <= wdata[CB_MONO];
                tft_q   <= wdata[CB_TFT];
                imask_q <= wdata[CB_IMASK +: 2];
                mode_q  <= new_mode;
                keep_q  <= wdata & CTRL_KEEP_MASK;
            end
            if (wr && sel.tim0) tim0_q <= wdata;
            if (wr && sel.tim1) tim1_q <= wdata;
            if (wr && sel.tim2) tim2_q <= wdata;
            if (wr && sel.subp) subp_q <= wdata & SUBP_WR_MASK;
        end
    end
endmodule

// File: rtl/disp_status_flags.sv
// Sticky status flags and the interrupt combine.
// Assumes event strobes take priority over clears in the same cycle.
module disp_status_flags
    import disp_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_fd,
    input  logic       ev_pd,
    input  logic       ev_se,
    input  logic       en_rise,
    input  logic       en_fall,
    input  logic [1:0] fall_mode,
    input  logic [1:0] imask,
    output logic       fd,
    output logic       pd,
    output logic       se,
    output logic       irq
);
    logic fd_nx, pd_nx, se_nx;

    // Next-state of each flag: apply transition rules first, then set on events.
    always_comb begin
        fd_nx = fd;
        pd_nx = pd;
        se_nx = se;
        if (en_rise) begin
            fd_nx = 1'b0;
            pd_nx = 1'b0;
        end
        if (en_fall) begin
            se_nx = 1'b0;
            if (fall_mode != MODE_NO_AUTO_FD) fd_nx = 1'b1;
        end
        fd_nx = fd_nx | ev_fd;
        pd_nx = pd_nx | ev_pd;
        se_nx = se_nx | ev_se;
    end

    // Flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fd <= 1'b0;
            pd <= 1'b0;
            se <= 1'b0;
        end else begin
            fd <= fd_nx;
            pd <= pd_nx;
            se <= se_nx;
        end
    end

    // Interrupt: masked frame/palette sources, unmasked sync error.
    always_comb irq = (fd & imask[0]) | (pd & imask[1]) | se;
endmodule

// File: rtl/disp_ctrl_regs.sv
// Top of the display register bank: decode, storage, flags and read mux.
// Assumes reads have no side effects and read data is combinational.
module disp_ctrl_regs
    import disp_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                ev_frame_done,
    input  logic                ev_palette_done,
    input  logic                ev_sync_err,
    output logic                irq,
    output logic                en_change,
    output logic                cfg_enable,
    output logic [1:0]          cfg_load_mode,
    output logic                cfg_tft,
    output logic                cfg_mono,
    output logic [SIZE_W-1:0]   cfg_width_m1,
    output logic [SIZE_W-1:0]   cfg_height_m1,
    output logic [31-SIZE_W:0]  cfg_htiming,
    output logic [31-SIZE_W:0]  cfg_vtiming,
    output logic [31:0]         cfg_timing2,
    output logic [31:0]         cfg_subpanel
);
    localparam int HI_W = REG_W - SIZE_W;

    reg_sel_t         sel;
    logic             en_q, mono_q, tft_q, en_rise, en_fall, chg_pulse;
    logic [1:0]       imask_q, mode_q, new_mode;
    logic [REG_W-1:0] keep_q, tim0_q, tim1_q, tim2_q, subp_q;
    logic             fd_q, pd_q, se_q;
    logic [REG_W-1:0] ctrl_rd, stat_rd;

    disp_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    disp_cfg_store u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .en_q      (en_q),
        .mono_q    (mono_q),
        .tft_q     (tft_q),
        .imask_q   (imask_q),
        .mode_q    (mode_q),
        .keep_q    (keep_q),
        .tim0_q    (tim0_q),
        .tim1_q    (tim1_q),
        .tim2_q    (tim2_q),
        .subp_q    (subp_q),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .new_mode  (new_mode),
        .chg_pulse (chg_pulse)
    );

    disp_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_fd     (ev_frame_done),
        .ev_pd     (ev_palette_done),
        .ev_se     (ev_sync_err),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .fall_mode (new_mode),
        .imask     (imask_q),
        .fd        (fd_q),
        .pd        (pd_q),
        .se        (se_q),
        .irq       (irq)
    );

    // Assemble the control and status read words.
    always_comb begin
        ctrl_rd = keep_q | CTRL_RD_ONES;
        ctrl_rd[CB_EN]        = 1'b1 & (en_q | ctrl_rd[CB_EN]);
        ctrl_rd[CB_MONO]      = mono_q | ctrl_rd[CB_MONO];
        ctrl_rd[CB_IMASK +: 2] = imask_q | ctrl_rd[CB_IMASK +: 2];
        ctrl_rd[CB_TFT]       = tft_q | ctrl_rd[CB_TFT];
        ctrl_rd[CB_TFT_DUP]   = tft_q | ctrl_rd[CB_TFT_DUP];
        ctrl_rd[CB_MODE +: 2] = mode_q | ctrl_rd[CB_MODE +: 2];
        stat_rd = '0;
        stat_rd[SB_FD] = fd_q;
        stat_rd[SB_SE] = se_q;
        stat_rd[SB_PD] = pd_q;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel.ctrl) bus_rdata = ctrl_rd;
        if (sel.tim0) bus_rdata = tim0_q | TIM0_RD_ONES;
        if (sel.tim1) bus_rdata = tim1_q;
        if (sel.tim2) bus_rdata = tim2_q | TIM2_RD_ONES;
        if (sel.stat) bus_rdata = stat_rd;
        if (sel.subp) bus_rdata = subp_q;
    end

    // Decoded configuration outputs.
    always_comb begin
        en_change     = chg_pulse;
        cfg_enable    = en_q;
        cfg_load_mode = mode_q;
        cfg_tft       = tft_q;
        cfg_mono      = mono_q;
        cfg_width_m1  = tim0_q[SIZE_W-1:0];
        cfg_height_m1 = tim1_q[SIZE_W-1:0];
        cfg_htiming   = tim0_q[REG_W-1 -: HI_W];
        cfg_vtiming   = tim1_q[REG_W-1 -: HI_W];
        cfg_timing2   = tim2_q;
        cfg_subpanel  = subp_q;
    end
endmodule

// File: rtl/disp_ctrl_regs_chk.sv
// Checker for the display register bank, attached to the top module by bind.
// Assumes the synchronous active-low reset of the top module.
module disp_ctrl_regs_chk
    import disp_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              ev_frame_done,
    input logic              ev_palette_done,
    input logic              ev_sync_err,
    input logic              irq,
    input logic              en_change,
    input logic              cfg_enable,
    input logic [1:0]        cfg_load_mode,
    input logic              fd,
    input logic              pd,
    input logic              se
);
    // R8: enable change is always reported by the pulse
    a_r8_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable != $past(cfg_enable)) |-> en_change);

    // R8: no pulse without an enable change
    a_r8_pulse_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        en_change |-> (cfg_enable != $past(cfg_enable)));

    // R7: a sync-error event raises the interrupt regardless of mask
    a_r7_sync_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_sync_err) |-> irq);

    // R9: disable with load mode other than 1 sets frame-done
    a_r9_fall_sets_fd: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_enable) && cfg_load_mode != MODE_NO_AUTO_FD) |-> fd);

    // R9: disable clears sync-error unless an event collides
    a_r9_fall_clears_se: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_enable) && !$past(ev_sync_err)) |-> !se);

    // R10: enable clears frame-done and palette-loaded
    a_r10_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_enable) && !$past(ev_frame_done) && !$past(ev_palette_done))
            |-> (!fd && !pd));

    // R2: control read always carries the fixed ones
    a_r2_ctrl_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |-> ((bus_rdata & CTRL_RD_ONES) == CTRL_RD_ONES));
endmodule

bind disp_ctrl_regs disp_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_rdata       (bus_rdata),
    .ev_frame_done   (ev_frame_done),
    .ev_palette_done (ev_palette_done),
    .ev_sync_err     (ev_sync_err),
    .irq             (irq),
    .en_change       (en_change),
    .cfg_enable      (cfg_enable),
    .cfg_load_mode   (cfg_load_mode),
    .fd              (fd_q),
    .pd              (pd_q),
    .se              (se_q)
);

// File: tb/test_disp_ctrl_regs.sv
// Directed bench for the display register bank; one task per scenario.
module test_disp_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_frame_done = 1'b0, ev_palette_done = 1'b0, ev_sync_err = 1'b0;
    logic        irq, en_change, cfg_enable, cfg_tft, cfg_mono;
    logic [1:0]  cfg_load_mode;
    logic [9:0]  cfg_width_m1, cfg_height_m1;
    logic [21:0] cfg_htiming, cfg_vtiming;
    logic [31:0] cfg_timing2, cfg_subpanel;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic last_pulse;

    always #2 clk = ~clk;

    disp_ctrl_regs i_disp_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_frame_done(ev_frame_done), .ev_palette_done(ev_palette_done),
        .ev_sync_err(ev_sync_err), .irq(irq), .en_change(en_change),
        .cfg_enable(cfg_enable), .cfg_load_mode(cfg_load_mode), .cfg_tft(cfg_tft),
        .cfg_mono(cfg_mono), .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
        .cfg_htiming(cfg_htiming), .cfg_vtiming(cfg_vtiming),
        .cfg_timing2(cfg_timing2), .cfg_subpanel(cfg_subpanel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Expected control read word from the last written word (R2).
    function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
        return ({31'd0, w[7]} << 23) | ({30'd0, w[21:20]} << 20) | ({31'd0, w[7]} << 7)
             | ({30'd0, w[4:3]} << 3) | ({31'd0, w[1]} << 1) | {31'd0, w[0]}
             | (w & 32'h01cff300) | 32'hfe000c34;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic se_ev = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; ev_sync_err = se_ev;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; ev_sync_err = 1'b0;
        last_pulse = en_change;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        ev_frame_done = (which == 0); ev_palette_done = (which == 1); ev_sync_err = (which == 2);
        @(negedge clk);
        ev_frame_done = 1'b0; ev_palette_done = 1'b0; ev_sync_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl", v, 32'hfe000c34);
        rd(8'h04, v); check("R1 tim0", v, 32'h0000000f);
        rd(8'h08, v); check("R1 tim1", v, 32'h0);
        rd(8'h0c, v); check("R1 tim2", v, 32'hfc000000);
        rd(8'h10, v); check("R1 stat", v, 32'h0);
        rd(8'h14, v); check("R1 subp", v, 32'h0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 pulse", {31'd0, en_change}, 0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(8'h00, 32'h0034_0089);
        check("R8 pulse on enable", {31'd0, last_pulse}, 1);
        @(negedge clk); check("R8 pulse one cycle", {31'd0, en_change}, 0);
        rd(8'h00, v); check("R2 ctrl read sparse", v, exp_ctrl(32'h0034_0089));
        check("R2 outputs", {26'd0, cfg_load_mode, cfg_tft, cfg_mono, cfg_enable, 1'b0},
              {26'd0, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0});
        wr(8'h00, 32'h0034_0089);
        check("R8 no pulse without change", {31'd0, last_pulse}, 0);
        wr(8'h00, 32'hffff_ffff);
        rd(8'h00, v); check("R2 ctrl read ones", v, exp_ctrl(32'hffff_ffff));
        wr(8'h00, 32'h0034_0089);
    endtask

    task automatic t_disable_modes();
        logic [31:0] v;
        wr(8'h00, 32'h0034_0088);
        check("R8 pulse on disable", {31'd0, last_pulse}, 1);
        rd(8'h10, v); check("R9 disable sets frame-done", v, 32'h1);
        check("R7 masked frame irq", {31'd0, irq}, 1);
        wr(8'h00, 32'h0010_0001);
        rd(8'h10, v); check("R10 enable clears frame-done", v, 32'h0);
        wr(8'h00, 32'h0010_0000);
        rd(8'h10, v); check("R9 mode 1 no frame-done", v, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0011);
        pulse_ev(0);
        rd(8'h10, v); check("R6 frame-done sticky", v, 32'h01);
        check("R7 frame-done masked off", {31'd0, irq}, 0);
        pulse_ev(1);
        rd(8'h10, v); check("R6 palette sticky", v, 32'h41);
        check("R7 palette irq", {31'd0, irq}, 1);
        wr(8'h10, 32'h0000_0000);
        rd(8'h10, v); check("R5 status write ignored", v, 32'h41);
        pulse_ev(2);
        rd(8'h10, v); check("R5 status layout", v, 32'h45);
        wr(8'h00, 32'h0000_0001);
        check("R7 sync unmasked", {31'd0, irq}, 1);
        wr(8'h00, 32'h0000_0000);
        rd(8'h10, v); check("R9 disable clears sync", v, 32'h41);
        check("R7 irq low", {31'd0, irq}, 0);
        wr(8'h00, 32'h0000_0001);
        rd(8'h10, v); check("R10 enable clears both", v, 32'h00);
        wr(8'h00, 32'h0000_0000, 1'b1);
        rd(8'h10, v); check("R12 event beats clear", v, 32'h05);
        check("R12 irq", {31'd0, irq}, 1);
    endtask

    task automatic t_timing_subp();
        logic [31:0] v;
        wr(8'h04, 32'hffff_fc05);
        rd(8'h04, v); check("R3 tim0 read", v, 32'hffff_fc0f);
        check("R3 width", {22'd0, cfg_width_m1}, 32'h5);
        check("R3 htiming", {10'd0, cfg_htiming}, 32'h003f_ffff);
        wr(8'h08, 32'h1234_5678);
        rd(8'h08, v); check("R3 tim1 read", v, 32'h1234_5678);
        check("R3 height", {22'd0, cfg_height_m1}, 32'h278);
        wr(8'h0c, 32'h0000_1234);
        rd(8'h0c, v); check("R3 tim2 read", v, 32'hfc00_1234);
        wr(8'h14, 32'hffff_ffff);
        rd(8'h14, v); check("R4 subpanel mask", v, 32'ha1ff_ffff);
        check("R4 output", cfg_subpanel, 32'ha1ff_ffff);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h18, 32'hffff_ffff);
        wr(8'h02, 32'hffff_ffff);
        rd(8'h18, v); check("R11 unmapped reads zero", v, 32'h0);
        rd(8'h02, v); check("R11 misaligned reads zero", v, 32'h0);
        rd(8'h00, v); check("R11 ctrl untouched", v, exp_ctrl(32'h0));
        rd(8'h14, v); check("R11 subp untouched", v, 32'ha1ff_ffff);
        rd(8'h0c, v); check("R11 tim2 untouched", v, 32'hfc00_1234);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_ctrl_fields();
        t_disable_modes();
        t_events();
        t_timing_subp();
        t_unmapped();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule